// File: doc/BRIEF.md
# SIMM DRAM Access Sequencer

This block drives a 72-pin DRAM SIMM from a 16-bit asynchronous processor bus of the 68000 kind. It runs from a fast clock at twice the processor rate and derives the processor clock from it by halving. A processor access to DRAM is seen when the address strobe is low, the DRAM select is high and at least one data strobe is low. The block then runs a fixed sequence. It puts out the row address with RAS low. One fast cycle later it puts out the column address with CAS low on the addressed byte lanes. It then acknowledges the transfer and holds that state until the address strobe rises. Last, it precharges for two cycles.

The 22-bit word address is folded onto an 11-bit multiplexed DRAM address. The row is formed from the even-numbered address bits and the column from the odd-numbered bits, so the mapping stays the same whatever the SIMM size (8 MB and larger). A free-running timer requests a CAS-before-RAS refresh every REFRESH_CYCLES fast cycles, 499 by default, which is about 15.6 µs at 32 MHz. The refresh is run only between processor accesses.

Top module: `simm_dram_ctrl`

## Requirements
- R1: `cpu_clk` is 0 while reset is held and inverts on every rising edge of `clk` after reset.
- R2: While reset is held, `ras_n`, `cas_n`, `we_n` and `dtack_n` are all high.
- R3: One cycle after an access is accepted, `ras_n` is low, `cas_n` is 2'b11 and `dram_addr[i]` equals `addr[2*i]` for i = 0..10.
- R4: In the next cycle, `ras_n` stays low, `dram_addr[i]` equals `addr[2*i+1]` and CAS is asserted.
- R5: `cas_n[1]` (upper lane) is low only if `uds_n` was low when the access was accepted, and `cas_n[0]` (lower lane) only if `lds_n` was low.
- R6: `we_n` equals `rd_wr_n` while RAS is low in a processor access (1 = read, 0 = write), and it is high at all other times.
- R7: `dtack_n` goes low in the cycle after CAS falls and stays low while `as_n` is low. It goes high in the same cycle that `as_n` goes high.
- R8: In the cycle after the acknowledge state ends, RAS and CAS are high. RAS then stays high for at least two cycles before it falls again.
- R9: Refresh starts exactly every REFRESH_CYCLES cycles when the bus is idle. It runs CAS low (both lanes) with RAS high for one cycle, then RAS low, with `we_n` high throughout.
- R10: When a refresh request and an access are pending at the same decision edge, the refresh runs first. The access row cycle follows five cycles after the CAS-before-RAS cycle.
- R11: No access starts while `dram_sel` is low or both data strobes are high, even with `as_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (twice the processor clock) |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Processor address strobe, active low |
| dram_sel | input | 1 | Address decoded as DRAM |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 22 | Word address |
| cpu_clk | output | 1 | Processor clock, fast clock divided by two |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| ras_n | output | 1 | Row address strobe |
| cas_n | output | 2 | Column strobes, bit 1 upper lane, bit 0 lower lane |
| we_n | output | 1 | DRAM write enable |
| dram_addr | output | 11 | Multiplexed row/column address |

## Verification
Every strobe and address output is registered. The row cycle therefore appears one clock after the decision edge, the column and acknowledge cycles one clock apart after that, and the precharge one and two clocks after the strobe release. The one exception is the acknowledge release, which follows `as_n` within the same cycle. The bench drives inputs on falling edges and samples outputs on the following falling edges. It finds the row cycle by its signature (RAS low, CAS high) and then checks each later cycle at a fixed count from it. The acknowledge release is checked a moment after `as_n` is driven high. Refresh spacing and the refresh-first priority are measured against a falling-edge counter, starting from an observed CAS-before-RAS cycle.

// File: rtl/simm_dram_pkg.sv
package simm_dram_pkg;

    localparam int DEF_ADDR_W   = 22;
    localparam int DEF_REF_CYC  = 499;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_ACK,
        ST_PRE1,
        ST_PRE2,
        ST_RF_CAS,
        ST_RF_RAS,
        ST_RF_HOLD
    } seq_state_e;

    typedef struct packed {
        logic       ras_n;
        logic [1:0] cas_n;
        logic       we_n;
        logic       col_sel;
    } dram_ctl_t;

    localparam dram_ctl_t CTL_QUIET = '{ras_n: 1'b1, cas_n: 2'b11, we_n: 1'b1, col_sel: 1'b0};

    function automatic dram_ctl_t ctl_for(input seq_state_e st, input logic rd,
                                          input logic [1:0] lanes_n);
        dram_ctl_t c;
        c = CTL_QUIET;
        case (st)
            ST_ROW: begin
                c.ras_n = 1'b0;
                c.we_n  = rd;
            end
            ST_COL, ST_ACK: begin
                c.ras_n   = 1'b0;
                c.cas_n   = lanes_n;
                c.we_n    = rd;
                c.col_sel = 1'b1;
            end
            ST_RF_CAS: c.cas_n = 2'b00;
            ST_RF_RAS, ST_RF_HOLD: begin
                c.ras_n = 1'b0;
                c.cas_n = 2'b00;
            end
            default: c = CTL_QUIET;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/simm_clk_div.sv
module simm_clk_div (
    input  logic clk,
    input  logic rst,
    output logic cpu_clk
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= ~half_q;
    end

    assign cpu_clk = half_q;

    // R1: processor clock inverts on every fast edge once out of reset
    a_r1_clk_toggles: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cpu_clk != $past(cpu_clk)));
endmodule

// File: rtl/simm_refresh_timer.sv
module simm_refresh_timer #(
    parameter int PERIOD = simm_dram_pkg::DEF_REF_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic req
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) req_q <= 1'b1;
            else if (ack)      req_q <= 1'b0;
        end
    end

    assign req = req_q;

    // R9: a pending refresh is kept until the sequencer takes it
    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> req);
endmodule

// File: rtl/simm_addr_mux.sv
module simm_addr_mux #(
    parameter int ADDR_W = simm_dram_pkg::DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                col_sel,
    output logic [ADDR_W/2-1:0] mux_addr
);
    localparam int MA_W = ADDR_W / 2;

    logic [MA_W-1:0] row_bits;
    logic [MA_W-1:0] col_bits;

    for (genvar i = 0; i < MA_W; i++) begin : g_fold
        assign row_bits[i] = addr[2*i];
        assign col_bits[i] = addr[2*i+1];
    end

    assign mux_addr = col_sel ? col_bits : row_bits;
endmodule

// File: rtl/simm_seq.sv
module simm_seq
    import simm_dram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic              dram_sel,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ref_req,
    output logic              ref_ack,
    output dram_ctl_t         ctl,
    output logic [ADDR_W-1:0] addr_lat,
    output logic              dtack_n
);
    seq_state_e        st_q, st_d;
    dram_ctl_t         ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic [1:0]        lanes_q;
    logic              acc_go;
    logic              take_acc;

    assign acc_go = !as_n && dram_sel && (!uds_n || !lds_n);

    always_comb begin
        st_d    = st_q;
        ref_ack = 1'b0;
        case (st_q)
            ST_IDLE, ST_PRE2: begin
                if (ref_req) begin
                    st_d    = ST_RF_CAS;
                    ref_ack = 1'b1;
                end else if (acc_go) begin
                    st_d = ST_ROW;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_ROW:     st_d = ST_COL;
            ST_COL:     st_d = ST_ACK;
            ST_ACK:     st_d = as_n ? ST_PRE1 : ST_ACK;
            ST_PRE1:    st_d = ST_PRE2;
            ST_RF_CAS:  st_d = ST_RF_RAS;
            ST_RF_RAS:  st_d = ST_RF_HOLD;
            ST_RF_HOLD: st_d = ST_PRE1;
            default:    st_d = ST_IDLE;
        endcase
    end

    assign take_acc = (st_d == ST_ROW);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ctl_q   <= CTL_QUIET;
            addr_q  <= '0;
            rd_q    <= 1'b1;
            lanes_q <= 2'b11;
        end else begin
            st_q <= st_d;
            if (take_acc) begin
                addr_q  <= addr;
                rd_q    <= rd_wr_n;
                lanes_q <= {uds_n, lds_n};
                ctl_q   <= ctl_for(st_d, rd_wr_n, {uds_n, lds_n});
            end else begin
                ctl_q   <= ctl_for(st_d, rd_q, lanes_q);
            end
        end
    end

    assign ctl      = ctl_q;
    assign addr_lat = addr_q;
    assign dtack_n  = !((st_q == ST_ACK) && !as_n);

    // R6: write enable is low only inside a RAS-low window
    a_r6_we_inside_ras: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.we_n |-> !ctl_q.ras_n);

    // R8: once RAS rises it stays high for the next cycle too
    a_r8_ras_precharge: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.ras_n) |=> ctl_q.ras_n);

    // R4/R9: CAS falls either after RAS (access) or alone on both lanes (refresh)
    a_r4_cas_order: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.cas_n != 2'b11 && $past(ctl_q.cas_n) == 2'b11) |->
        (!$past(ctl_q.ras_n) || (ctl_q.ras_n && ctl_q.cas_n == 2'b00)));

    // R7: acknowledge only while an access holds RAS and a CAS lane low
    a_r7_dtack_in_access: assert property (@(posedge clk) disable iff (rst)
        !dtack_n |-> (!ctl_q.ras_n && ctl_q.cas_n != 2'b11 && ctl_q.col_sel));

    // R10: a refresh never starts while RAS is low
    a_r10_refresh_when_idle: assert property (@(posedge clk) disable iff (rst)
        ref_ack |-> ctl_q.ras_n);
endmodule

// File: rtl/simm_dram_ctrl.sv
module simm_dram_ctrl
    import simm_dram_pkg::*;
#(
    parameter int ADDR_W         = DEF_ADDR_W,
    parameter int REFRESH_CYCLES = DEF_REF_CYC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                as_n,
    input  logic                dram_sel,
    input  logic                uds_n,
    input  logic                lds_n,
    input  logic                rd_wr_n,
    input  logic [ADDR_W-1:0]   addr,
    output logic                cpu_clk,
    output logic                dtack_n,
    output logic                ras_n,
    output logic [1:0]          cas_n,
    output logic                we_n,
    output logic [ADDR_W/2-1:0] dram_addr
);
    localparam int MA_W = ADDR_W / 2;

    logic              ref_req;
    logic              ref_ack;
    dram_ctl_t         ctl;
    logic [ADDR_W-1:0] addr_lat;
    logic [MA_W-1:0]   mux_addr;

    simm_clk_div u_div (
        .clk     (clk),
        .rst     (rst),
        .cpu_clk (cpu_clk)
    );

    simm_refresh_timer #(.PERIOD(REFRESH_CYCLES)) u_ref (
        .clk (clk),
        .rst (rst),
        .ack (ref_ack),
        .req (ref_req)
    );

    simm_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .as_n     (as_n),
        .dram_sel (dram_sel),
        .uds_n    (uds_n),
        .lds_n    (lds_n),
        .rd_wr_n  (rd_wr_n),
        .addr     (addr),
        .ref_req  (ref_req),
        .ref_ack  (ref_ack),
        .ctl      (ctl),
        .addr_lat (addr_lat),
        .dtack_n  (dtack_n)
    );

    simm_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .addr     (addr_lat),
        .col_sel  (ctl.col_sel),
        .mux_addr (mux_addr)
    );

    assign ras_n     = ctl.ras_n;
    assign cas_n     = ctl.cas_n;
    assign we_n      = ctl.we_n;
    assign dram_addr = mux_addr;
endmodule

// File: tb/sim_simm_dram_ctrl.sv
module sim_simm_dram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 22;
    localparam int MW  = AW / 2;
    localparam int REF = 499;
    localparam int NVEC = 8;

    // {addr[21:0], rd_wr_n, uds_n, lds_n}
    localparam logic [AW+2:0] VEC [NVEC] = '{
        {22'h000000, 1'b1, 1'b0, 1'b0},
        {22'h3FFFFF, 1'b0, 1'b0, 1'b0},
        {22'h155555, 1'b1, 1'b0, 1'b1},
        {22'h2AAAAA, 1'b0, 1'b1, 1'b0},
        {22'h123456, 1'b0, 1'b0, 1'b1},
        {22'h0ABCDE, 1'b1, 1'b1, 1'b0},
        {22'h3C3C3C, 1'b0, 1'b0, 1'b0},
        {22'h000001, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic as_n = 1'b1, dram_sel = 1'b0, uds_n = 1'b1, lds_n = 1'b1, rd_wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic cpu_clk, dtack_n, ras_n, we_n;
    logic [1:0] cas_n;
    logic [MW-1:0] dram_addr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    simm_dram_ctrl #(.ADDR_W(AW), .REFRESH_CYCLES(REF)) u0 (
        .clk(clk), .rst(rst), .as_n(as_n), .dram_sel(dram_sel), .uds_n(uds_n),
        .lds_n(lds_n), .rd_wr_n(rd_wr_n), .addr(addr), .cpu_clk(cpu_clk),
        .dtack_n(dtack_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .dram_addr(dram_addr)
    );

    function automatic logic [MW-1:0] exp_row(input logic [AW-1:0] a);
        logic [MW-1:0] r;
        for (int i = 0; i < MW; i++) r[i] = a[2*i];
        return r;
    endfunction

    function automatic logic [MW-1:0] exp_col(input logic [AW-1:0] a);
        logic [MW-1:0] r;
        for (int i = 0; i < MW; i++) r[i] = a[2*i+1];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic bus_idle();
        as_n = 1'b1; dram_sel = 1'b0; uds_n = 1'b1; lds_n = 1'b1; rd_wr_n = 1'b1;
    endtask

    task automatic wait_row(output bit found);
        int n = 0;
        found = 0;
        while (n < 40 && !found) begin
            @(negedge clk);
            n++;
            if (ras_n === 1'b0 && cas_n === 2'b11) found = 1;
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input logic rd, input logic u, input logic l);
        bit found;
        @(negedge clk);
        addr = a; rd_wr_n = rd; uds_n = u; lds_n = l; dram_sel = 1'b1; as_n = 1'b0;
        wait_row(found);
        chk("R3 row cycle seen", {31'd0, found}, 32'd1);
        chk("R3 row address", {21'd0, dram_addr}, {21'd0, exp_row(a)});
        chk("R6 we_n in row", {31'd0, we_n}, {31'd0, rd});
        @(negedge clk);
        chk("R4 col address", {21'd0, dram_addr}, {21'd0, exp_col(a)});
        chk("R4 ras held", {31'd0, ras_n}, 32'd0);
        chk("R5 cas lanes", {30'd0, cas_n}, {30'd0, u, l});
        chk("R6 we_n in col", {31'd0, we_n}, {31'd0, rd});
        @(negedge clk);
        chk("R7 dtack asserted", {31'd0, dtack_n}, 32'd0);
        @(negedge clk);
        chk("R7 dtack held", {31'd0, dtack_n}, 32'd0);
        bus_idle();
        #1;
        chk("R7 dtack released with as_n", {31'd0, dtack_n}, 32'd1);
        @(negedge clk);
        chk("R8 precharge 1 strobes high", {29'd0, ras_n, cas_n}, 32'd7);
        chk("R6 we_n high after access", {31'd0, we_n}, 32'd1);
        @(negedge clk);
        chk("R8 precharge 2 ras high", {31'd0, ras_n}, 32'd1);
    endtask

    initial begin
        int t1, t2;
        bit seen;
        // R2 / R1 reset state
        repeat (4) @(negedge clk);
        chk("R2 reset strobes", {27'd0, ras_n, cas_n, we_n, dtack_n}, 32'h1F);
        chk("R1 cpu_clk in reset", {31'd0, cpu_clk}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            logic prev;
            prev = cpu_clk;
            @(negedge clk);
            chk("R1 cpu_clk toggles", {31'd0, cpu_clk}, {31'd0, ~prev});
        end

        // table walk: R3..R8
        for (int v = 0; v < NVEC; v++) begin
            access(VEC[v][AW+2:3], VEC[v][2], VEC[v][1], VEC[v][0]);
        end

        // R11: not selected, then no strobes
        @(negedge clk);
        addr = 22'h012345; as_n = 1'b0; dram_sel = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (ras_n === 1'b0 && cas_n === 2'b11) seen = 1;
        end
        chk("R11 no access without select", {31'd0, seen}, 32'd0);
        dram_sel = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (ras_n === 1'b0 && cas_n === 2'b11) seen = 1;
        end
        chk("R11 no access without data strobes", {31'd0, seen}, 32'd0);
        bus_idle();

        // R9: refresh spacing and sequence
        seen = 0; t1 = 0;
        for (int k = 0; k < REF + 20 && !seen; k++) begin
            @(negedge clk);
            if (ras_n === 1'b1 && cas_n === 2'b00) begin seen = 1; t1 = cyc; end
        end
        chk("R9 first refresh seen", {31'd0, seen}, 32'd1);
        seen = 0; t2 = 0;
        for (int k = 0; k < REF + 20 && !seen; k++) begin
            @(negedge clk);
            if (ras_n === 1'b1 && cas_n === 2'b00) begin seen = 1; t2 = cyc; end
        end
        chk("R9 refresh interval", t2 - t1, REF);
        chk("R9 cbr we_n high", {31'd0, we_n}, 32'd1);
        @(negedge clk);
        chk("R9 ras after cas", {28'd0, ras_n, cas_n, we_n}, 32'd1);

        // R10: refresh wins over a simultaneous access
        while (cyc < t2 + REF - 1) @(negedge clk);
        addr = 22'h2D2D2D; rd_wr_n = 1'b1; uds_n = 1'b0; lds_n = 1'b0;
        dram_sel = 1'b1; as_n = 1'b0;
        @(negedge clk);
        chk("R10 refresh first", {29'd0, ras_n, cas_n}, 32'd4);
        repeat (5) @(negedge clk);
        chk("R10 access row after refresh", {29'd0, ras_n, cas_n}, 32'd3);
        chk("R10 row address", {21'd0, dram_addr}, {21'd0, exp_row(22'h2D2D2D)});
        repeat (2) @(negedge clk);
        bus_idle();
        repeat (3) @(negedge clk);
        chk("R8 idle after access", {29'd0, ras_n, cas_n}, 32'd7);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule